// File: doc/BRIEF.md
# Programmable Pixel Component Extractor

This block turns one packed framebuffer pixel word into an 8-bit red, green and blue triple. A small register set, written through a simple write port, gives the number of valid bytes in a pixel. For each colour it also gives the lowest bit of that colour's field, the field width in bits, and a default value. The default value stands in whenever the component cannot or should not be taken from the pixel.

Every cycle the block takes one pixel word together with two qualifiers. One says that the pixel lies inside the visible area. The other says that the upstream fetch ran dry (an underrun). The 24-bit result leaves through a single output register, one cycle after its inputs. Fetching the framebuffer, generating the display timing and converting between colour spaces are done elsewhere.

Register map: address 0 is the pixel format, and addresses 1, 2 and 3 are the colour selects for red, green and blue.

Top module: `pix_extract`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `rgb_out` is zero. Reset also sets every register to zero, so the format is one byte per pixel and every colour has width zero and default zero.
- R2: The format register sits at address 0 and holds the byte count minus one in bits [4:3]. Pixel bytes above the last valid byte read as zero, and so does any field bit that lies beyond the pixel word.
- R3: The colour select registers sit at address 1 (red), address 2 (green) and address 3 (blue). Each one holds the lowest field bit index in bits [4:0], the field width in bits [11:8] and the default value in bits [23:16]. In `rgb_out`, red occupies [23:16], green [15:8] and blue [7:0].
- R4: A colour whose field width is zero outputs its default value.
- R5: When the visible flag is low, all three components output their default values.
- R6: When the underrun flag is high, all three components output their default values, whatever the visible flag says.
- R7: A field narrower than 8 bits is placed at the top of the component. The field pattern is then repeated downward, most significant bit first, until all 8 bits are filled.
- R8: A field of 8 to 15 bits gives the 8 most significant bits of the field, which are the 8 bits that end at bit index lsb+width-1.
- R9: `rgb_out` shows the result for the inputs sampled at the previous rising clock edge.
- R10: A register write affects the pixel in the next cycle. A pixel presented in the same cycle as the write is converted with the settings that applied before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 format, 1 red, 2 green, 3 blue) |
| cfg_wdata | input | 32 | Register write data |
| pix_in | input | 8*NBYTES | Packed pixel word, byte 0 in the low bits |
| vis_in | input | 1 | Pixel lies inside the visible area |
| undr_in | input | 1 | Buffer underrun for this pixel |
| rgb_out | output | 24 | Registered red, green and blue components |

## Verification
The bench builds the block with its default setting of NBYTES = 4, which makes the pixel word 32 bits wide. The lowest-bit field is 5 bits, so every field position the register can name falls inside or just past that word. The red channel is swept over every byte count, every lowest-bit index and every width. This covers byte masking, fields that run past the pixel word, the repeat-downward fill for narrow fields and the truncation of wide fields. Directed cases cover the default conditions, the reset state and a write that lands in the same cycle as a pixel.

// File: rtl/pix_extract.sv
module pix_extract #(
  parameter int NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_addr,
  input  logic [31:0]           cfg_wdata,
  input  logic [8*NBYTES-1:0]   pix_in,
  input  logic                  vis_in,
  input  logic                  undr_in,
  output logic [23:0]           rgb_out
);
  localparam int PW = 8 * NBYTES;
  localparam int BW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [BW-1:0]       bpp_m1;
  logic [2:0][7:0]     def_q;
  logic [2:0][3:0]     cnt_q;
  logic [2:0][4:0]     lsb_q;
  logic [PW-1:0]       pix_m;
  logic [2:0][7:0]     comp;
  logic                force_def;
  logic                unused_wdata;

  assign unused_wdata = ^{cfg_wdata[31:24], cfg_wdata[15:12], cfg_wdata[7:5],
                          cfg_wdata[2:0], cfg_wdata[31:3+BW]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bpp_m1 <= '0;
    else if (cfg_we && cfg_addr == 2'd0) bpp_m1 <= cfg_wdata[3 +: BW];

  function automatic logic [7:0] pick(input logic [PW-1:0] px,
                                      input logic [4:0] lsb,
                                      input logic [3:0] cnt);
    logic [7:0] o;
    int idx;
    int n;
    int l;
    n = int'(cnt);
    l = int'(lsb);
    o = '0;
    for (int j = 0; j < 8; j++) begin
      if (n >= 8)     idx = l + n - 8 + j;
      else if (n > 0) idx = l + n - 1 - ((7 - j) % n);
      else            idx = PW;
      if (idx < PW) o[j] = px[idx];
    end
    return o;
  endfunction

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign pix_m[8*b +: 8] = (BW'(b) <= bpp_m1) ? pix_in[8*b +: 8] : 8'h00;
  end

  assign force_def = !vis_in || undr_in;

  for (genvar c = 0; c < 3; c++) begin : g_col
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        def_q[c] <= '0;
        cnt_q[c] <= '0;
        lsb_q[c] <= '0;
      end else if (cfg_we && cfg_addr == 2'(c + 1)) begin
        def_q[c] <= cfg_wdata[23:16];
        cnt_q[c] <= cfg_wdata[11:8];
        lsb_q[c] <= cfg_wdata[4:0];
      end

    assign comp[c] = (force_def || cnt_q[c] == 4'd0) ? def_q[c]
                   : pick(pix_m, lsb_q[c], cnt_q[c]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rgb_out <= '0;
    else        rgb_out <= {comp[0], comp[1], comp[2]};
endmodule

module pix_extract_chk #(
  parameter int NBYTES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vis_in,
  input logic               undr_in,
  input logic [23:0]        rgb_out,
  input logic [2:0][7:0]    def_q,
  input logic [2:0][3:0]    cnt_q
);
  logic unused_p;
  assign unused_p = (NBYTES == 0);

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> rgb_out == 24'h0);

  a_r5_invisible_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    !vis_in |=> rgb_out == $past({def_q[0], def_q[1], def_q[2]}));

  a_r6_underrun_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    undr_in |=> rgb_out == $past({def_q[0], def_q[1], def_q[2]}));

  a_r4_red_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[0] == 4'd0 |=> rgb_out[23:16] == $past(def_q[0]));

  a_r4_green_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[1] == 4'd0 |=> rgb_out[15:8] == $past(def_q[1]));

  a_r4_blue_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[2] == 4'd0 |=> rgb_out[7:0] == $past(def_q[2]));
endmodule

bind pix_extract pix_extract_chk #(.NBYTES(NBYTES)) u_chk (.*);

// File: tb/sim_pix_extract.sv
`timescale 1ns/1ps
module sim_pix_extract;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] pix_in = '0;
  logic        vis_in = 1'b0;
  logic        undr_in = 1'b0;
  logic [23:0] rgb_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pix_extract u0 (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
                  .pix_in, .vis_in, .undr_in, .rgb_out);

  function automatic logic [7:0] model(input longint pix, input int bpp,
                                       input int lsb, input int cnt, input logic [7:0] dflt);
    longint m, f, acc;
    int bits;
    if (cnt == 0) return dflt;
    m = pix & ((64'd1 << (8 * bpp)) - 1);
    f = (m >> lsb) & ((64'd1 << cnt) - 1);
    if (cnt >= 8) return 8'(f >> (cnt - 8));
    acc = 0;
    bits = 0;
    while (bits < 8) begin
      acc = (acc << cnt) | f;
      bits += cnt;
    end
    return 8'(acc >> (bits - 8));
  endfunction

  function automatic logic [31:0] sel(input int lsb, input int cnt, input logic [7:0] dflt);
    return {8'h00, dflt, 4'h0, 4'(cnt), 3'b000, 5'(lsb)};
  endfunction

  task automatic chk(input string req, input logic [23:0] exp);
    checks++;
    if (rgb_out !== exp) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", req, rgb_out, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic px(input logic [31:0] p, input logic v, input logic u);
    @(negedge clk);
    pix_in = p; vis_in = v; undr_in = u;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'hA5C3_96F1;
    pats[1] = 32'h5E17_2BD8;
    pats[2] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R1 reset output", 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle after reset", 24'h0);
    px(32'hFFFF_FFFF, 1'b1, 1'b0);
    chk("R1 zero defaults after reset", 24'h0);

    wr(2'd2, sel(0, 0, 8'h5A));
    wr(2'd3, sel(4, 4, 8'h11));
    for (int bpp = 1; bpp <= 4; bpp++) begin
      wr(2'd0, 32'((bpp - 1) << 3));
      for (int lsb = 0; lsb < 32; lsb++)
        for (int cnt = 0; cnt < 16; cnt++) begin
          wr(2'd1, sel(lsb, cnt, 8'hC7));
          for (int k = 0; k < 3; k++) begin
            px(pats[k], 1'b1, 1'b0);
            chk(cnt == 0 ? "R4 zero width" : (cnt < 8 ? "R7 narrow fill R2 R3" : "R8 wide field R2 R3"),
                {model(pats[k], bpp, lsb, cnt, 8'hC7), 8'h5A,
                 model(pats[k], bpp, 4, 4, 8'h11)});
          end
        end
    end

    wr(2'd0, 32'h18);
    wr(2'd1, sel(8, 8, 8'h22));
    px(32'h0012_3400, 1'b0, 1'b0);
    chk("R5 invisible pixel", 24'h225A11);
    px(32'h0012_3400, 1'b1, 1'b1);
    chk("R6 underrun", 24'h225A11);
    px(32'h0012_3400, 1'b0, 1'b1);
    chk("R6 underrun and invisible", 24'h225A11);
    px(32'h0012_3400, 1'b1, 1'b0);
    chk("R9 visible pixel", {8'h34, 8'h5A, 8'h00});

    @(negedge clk);
    pix_in = 32'h0000_AB00; vis_in = 1'b1; undr_in = 1'b0;
    cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = sel(12, 4, 8'h22);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R10 same-cycle write uses old setting", {8'hAB, 8'h5A, 8'h00});
    @(negedge clk);
    chk("R10 next pixel uses new setting", {8'hAA, 8'h5A, 8'h00});

    @(negedge clk);
    pix_in = 32'h0000_7700;
    @(posedge clk);
    #1;
    chk("R9 output updates one edge after input", {8'h77, 8'h5A, 8'h00});

    wr(2'd0, 32'h0);
    px(32'h0000_7700, 1'b1, 1'b0);
    chk("R2 byte above count masked", {8'h00, 8'h5A, 8'h00});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule